// File: doc/BRIEF.md
# Two-Bank Hotspot Cartridge Mapper

This block sits on the cartridge side of a small 8-bit system bus. It holds an 8 KiB ROM image as two 4 KiB banks. The processor sees one of the banks through a 4 KiB window, which is every address with bit 12 set. No control register exists. The active bank changes whenever the processor touches one of two fixed addresses at the top of the window, on a read or on a write. A read of any other window address returns the byte at the current bank and the low twelve address bits. The data and an output enable appear one clock after the access.

A debug port lets tooling read the window without disturbing the machine. An access made with the peek flag set returns the byte like a read does. It never moves the bank selection, even when it lands on a switching address. Addresses with bit 12 clear belong to other devices on the console. The mapper neither answers them nor reacts to them.

The ROM image is a fixed computed pattern that stands in for the mask contents. Loading an image, detecting the cartridge format and on-cartridge RAM are outside this block.

Top module: `hotspot_bank_mapper`

## Requirements
- R1: After a synchronous active-high reset, bank 1 is active. The registered outputs are zero: `rd_oe` is 0 and `rd_data` is 0x00.
- R2: A non-peek access with `bus_strobe` high at address 0x1FF8 selects bank 0 for every later access.
- R3: A non-peek access with `bus_strobe` high at address 0x1FF9 selects bank 1 for every later access.
- R4: A write (`bus_wr`=1, `dbg_peek`=0) to a switching address changes the bank like a read does, and the written data plays no part. No write raises `rd_oe` in the following cycle.
- R5: A read of a switching address returns the byte of the bank that was active before the access. The new bank applies from the next access onward.
- R6: An access with `dbg_peek`=1 is treated as a read whatever `bus_wr` is. It returns data with `rd_oe`, and it never changes the bank, including at 0x1FF8 and 0x1FF9.
- R7: A read of a window address A sets `rd_oe` to 1 and `rd_data` to ROM[{bank, A[11:0]}] in the cycle after the access. ROM byte i (13-bit index i) equals (i[7:0] + {i[12:8], 3'b011}) mod 256.
- R8: An access with A[12]=0 leaves `rd_oe` at 0 in the next cycle and does not affect the bank, including at 0x0FF8 and 0x0FF9.
- R9: In a cycle after `bus_strobe` was low, `rd_oe` is 0 and `rd_data` is 0x00, and the bank is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Processor address |
| bus_strobe | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| dbg_peek | input | 1 | Debug read that must not change the bank |
| rd_data | output | 8 | Registered ROM byte, zero when not enabled |
| rd_oe | output | 1 | Registered output enable for `rd_data` |

## Verification
The bench starts on the reset bank. It reads both switching addresses directly, and it checks that such a read returns the old bank's byte. A design that switched before the lookup would return the new bank's byte there. Peeks at the switching addresses and accesses to their aliases with bit 12 clear are followed by an ordinary read. A design that let either of them move the bank would return the other bank's byte. Writes to the switching addresses must switch the bank and raise no enable. A long random mix, biased toward the switching addresses, the aliases and peeks, catches any path where the bank model and the design drift apart.

// File: rtl/hotspot_mapper_pkg.sv
package hotspot_mapper_pkg;
  localparam int unsigned MAP_ADDR_W = 13;
  localparam int unsigned MAP_OFS_W  = 12;
  localparam int unsigned MAP_DATA_W = 8;
  localparam logic [MAP_ADDR_W-1:0] MAP_HOT_B0 = 13'h1FF8;
  localparam logic [MAP_ADDR_W-1:0] MAP_HOT_B1 = 13'h1FF9;

  typedef enum logic {BANK_LOW = 1'b0, BANK_HIGH = 1'b1} bank_e;

  // Fixed image: byte i = i[7:0] + {i[12:8],3'b011}, truncated to a byte.
  function automatic logic [MAP_DATA_W-1:0] rom_pattern(input int unsigned idx);
    int unsigned sum;
    sum = (idx & 32'hFF) + ((idx >> 8) << 3) + 32'd3;
    return MAP_DATA_W'(sum);
  endfunction
endpackage

// File: rtl/hotspot_decode.sv
module hotspot_decode
  import hotspot_mapper_pkg::*;
#(
  parameter int unsigned ADDR_W = MAP_ADDR_W,
  parameter logic [ADDR_W-1:0] HOT_B0 = MAP_HOT_B0,
  parameter logic [ADDR_W-1:0] HOT_B1 = MAP_HOT_B1
) (
  input  logic              strobe,
  input  logic              peek,
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              go_b0,
  output logic              go_b1
);
  localparam int unsigned WIN_BIT = ADDR_W - 1;

  logic may_switch;

  always_comb begin
    win_hit    = strobe && addr[WIN_BIT];
    may_switch = win_hit && !peek;
    go_b0      = may_switch && (addr == HOT_B0);
    go_b1      = may_switch && (addr == HOT_B1);
  end
endmodule

// File: rtl/bank_select.sv
module bank_select
  import hotspot_mapper_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go_b0,
  input  logic  go_b1,
  output bank_e bank_q
);
  always_ff @(posedge clk) begin
    if (rst)        bank_q <= BANK_HIGH;
    else if (go_b0) bank_q <= BANK_LOW;
    else if (go_b1) bank_q <= BANK_HIGH;
  end

  // R1
  reset_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bank_q == BANK_HIGH);
  // R2
  to_low_chk: assert property (@(posedge clk) disable iff (rst)
    go_b0 |=> bank_q == BANK_LOW);
  // R3
  to_high_chk: assert property (@(posedge clk) disable iff (rst)
    go_b1 |=> bank_q == BANK_HIGH);
  // R6
  hold_bank_chk: assert property (@(posedge clk) disable iff (rst)
    !(go_b0 || go_b1) |=> $stable(bank_q));
endmodule

// File: rtl/pattern_rom.sv
module pattern_rom
  import hotspot_mapper_pkg::*;
#(
  parameter int unsigned OFS_W  = MAP_OFS_W,
  parameter int unsigned DATA_W = MAP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [OFS_W:0]    idx,
  output logic [DATA_W-1:0] q,
  output logic              q_vld
);
  localparam int unsigned IDX_W = OFS_W + 1;

  logic [DATA_W-1:0] word;

  always_comb word = DATA_W'(rom_pattern(int'({{(32-IDX_W){1'b0}}, idx})));

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q     <= rd_en ? word : '0;
      q_vld <= rd_en;
    end
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (q == '0 && !q_vld));
endmodule

// File: rtl/hotspot_bank_mapper.sv
module hotspot_bank_mapper
  import hotspot_mapper_pkg::*;
#(
  parameter int unsigned ADDR_W = MAP_ADDR_W,
  parameter int unsigned OFS_W  = MAP_OFS_W,
  parameter int unsigned DATA_W = MAP_DATA_W,
  parameter logic [ADDR_W-1:0] HOT_B0 = MAP_HOT_B0,
  parameter logic [ADDR_W-1:0] HOT_B1 = MAP_HOT_B1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic              bus_wr,
  input  logic              dbg_peek,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  logic        win_hit, go_b0, go_b1, rd_en;
  bank_e       bank_q;
  logic [OFS_W:0] rom_idx;

  hotspot_decode #(.ADDR_W(ADDR_W), .HOT_B0(HOT_B0), .HOT_B1(HOT_B1)) u_dec (
    .strobe(bus_strobe), .peek(dbg_peek), .addr(bus_addr),
    .win_hit(win_hit), .go_b0(go_b0), .go_b1(go_b1)
  );

  bank_select u_bank (
    .clk(clk), .rst(rst), .go_b0(go_b0), .go_b1(go_b1), .bank_q(bank_q)
  );

  always_comb begin
    rd_en   = win_hit && (!bus_wr || dbg_peek);
    rom_idx = {bank_q, bus_addr[OFS_W-1:0]};
  end

  pattern_rom #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(rd_en), .idx(rom_idx),
    .q(rd_data), .q_vld(rd_oe)
  );

  // R8
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !bus_addr[ADDR_W-1]) |=> !rd_oe);
  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_wr && !dbg_peek) |=> !rd_oe);
  // R6
  peek_no_switch_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_peek |-> !(go_b0 || go_b1));
  // R7
  window_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_addr[ADDR_W-1] && (!bus_wr || dbg_peek)) |=> rd_oe);
endmodule

// File: tb/test_hotspot_bank_mapper.sv
`timescale 1ns/1ps
module test_hotspot_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] bus_addr = '0;
  logic        bus_strobe = 1'b0, bus_wr = 1'b0, dbg_peek = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;
  bit mbank = 1'b1;

  always #2.5 clk = ~clk;

  hotspot_bank_mapper i_hotspot_bank_mapper (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .bus_wr(bus_wr), .dbg_peek(dbg_peek), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  function automatic logic [7:0] exp_byte(input bit b, input logic [11:0] ofs);
    logic [12:0] i;
    i = {b, ofs};
    return i[7:0] + {i[12:8], 3'b011};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed access, checked one cycle later against the bench model.
  task automatic access(input logic [12:0] a, input bit wr, input bit pk,
                        input logic [7:0] wdata, input string req);
    bit rd;
    logic [8:0] exp;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; dbg_peek = pk; bus_strobe = 1'b1;
    rd  = a[12] && (!wr || pk);
    exp = rd ? {1'b1, exp_byte(mbank, a[11:0])} : 9'h000;
    if (a[12] && !pk && a == 13'h1FF8) mbank = 1'b0;
    if (a[12] && !pk && a == 13'h1FF9) mbank = 1'b1;
    if (wdata == 8'hFF) bus_addr = a; // data has no bus path; value is ignored
    @(negedge clk);
    bus_strobe = 1'b0;
    check(req, {rd_oe, rd_data}, exp);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R9", {rd_oe, rd_data}, 9'h000);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {rd_oe, rd_data}, 9'h000);
    access(13'h1000, 0, 0, 0, "R1");          // bank 1 after reset
    idle_check();
    access(13'h1FF8, 0, 0, 0, "R5");          // old bank byte returned
    access(13'h1000, 0, 0, 0, "R2");          // now bank 0
    access(13'h1FF9, 0, 1, 0, "R6");          // peek, no switch
    access(13'h1000, 0, 0, 0, "R6");
    access(13'h1FF9, 0, 0, 0, "R5");
    access(13'h1ABC, 0, 0, 0, "R3");          // bank 1
    access(13'h1FF8, 1, 0, 8'h5A, "R4");      // write switches, no oe
    access(13'h1ABC, 0, 0, 0, "R4");
    access(13'h1FF9, 1, 0, 8'hFF, "R4");
    access(13'h1ABC, 0, 0, 0, "R4");
    access(13'h0FF8, 0, 0, 0, "R8");          // alias below window
    access(13'h1234, 0, 0, 0, "R8");
    access(13'h1FF8, 1, 1, 0, "R6");          // peek with wr flag reads
    access(13'h1234, 0, 0, 0, "R6");
    access(13'h1FFF, 0, 0, 0, "R7");
    void'($urandom(32'd2600));
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      logic [12:0] a;
      r = $urandom % 8;
      case (r)
        0: a = 13'h1FF8;
        1: a = 13'h1FF9;
        2: a = 13'h0FF8;
        3: a = 13'h0FF9;
        default: a = 13'($urandom);
      endcase
      access(a, ($urandom % 4) == 0, ($urandom % 5) == 0, 8'($urandom), "R7");
      if (($urandom % 6) == 0) idle_check();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule